// File: doc/BRIEF.md
# I2C Master Byte Receiver with Per-Byte Wait

This block is the receive engine of an I2C bus master. Once software has put it in receive mode and made a dummy read of the data register, it generates SCL from the system clock. It shifts in one byte per nine SCL cycles and answers each byte on the ninth cycle with an acknowledge bit chosen by software. Bytes follow one another with no gap until software switches the block back to transmit mode. Start conditions, stop conditions and arbitration are handled elsewhere.

An optional wait lets software service every byte. When wait is on, SCL is held low after the eighth data clock and the interrupt flag rises. Software can then still choose the acknowledge value, and it releases the bus by clearing the flag. A second interrupt follows at the rising edge of the ninth clock, when the byte lands in the data register. The done flag tells the two interrupts apart. Both bus lines are modelled as open-drain pull-down enables.

Top module: `i2c_rx_wait`

## Requirements
- R1: After reset SCL and SDA are released, `irq` is 0, the control register (address 1) reads 0x01 (transmit mode) and the status register (address 2) reads 0x00.
- R2: A read of address 0 while control bit 0 is 0 and the engine is idle starts reception. SCL is pulled low first, and each SCL cycle has a low phase and a high phase of HALF_CYC clocks each.
- R3: SDA is sampled at each of the first eight SCL rising edges of a frame, MSB first. The assembled byte becomes readable at address 0 from the clock after the ninth rising edge.
- R4: With wait enabled (control bit 2), the falling edge of the eighth SCL cycle sets status bit 0 with status bit 1 at 0. SCL then stays low until status bit 0 is cleared.
- R5: During both phases of the ninth SCL cycle SDA is pulled low when the acknowledge value (control bit 1) is 0 and released when it is 1. SDA is released at all other times.
- R6: The rising edge of the ninth SCL cycle sets status bits 0 (interrupt), 1 (frame done) and 2 (data full).
- R7: With wait disabled, frames follow back to back with no stall, giving one byte every 18·HALF_CYC clocks.
- R8: `irq` is high exactly when status bit 0 and control bit 3 (interrupt enable) are both 1.
- R9: Writing 0 to status bit 0 clears status bits 0 and 1. Reading address 0 clears status bit 2. Writing 1 to status bit 0 changes nothing. A flag being set in the same cycle wins over a clear.
- R10: Setting control bit 0 (transmit mode) during a frame lets that frame finish its ninth clock. The engine then releases SCL and starts no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on address 0) |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The engine is tried with the wait on and acknowledge 0, then with a late switch to NACK and transmit mode. This separates the two interrupt stages, shows that SCL is held through the eighth-clock stall, and shows that the mode change waits for the ninth clock. A continuous run with wait off and interrupts masked measures the byte-to-byte period, which would reveal a spurious stall, and shows that flags still set while `irq` stays low. Five different bytes, each with a distinct bit pattern, reveal a wrong bit order or a sampling edge that is off by one. Flag-clear writes of 0 and of 1, and data reads, are checked against the status register.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_BITS = 8;
  localparam int REG_W     = 8;
  localparam int WR_W      = 4;
  localparam logic [3:0] SLOT_FIRST = 4'd1;
  localparam logic [3:0] SLOT_LAST  = 4'd8;
  localparam logic [3:0] SLOT_ACK   = 4'd9;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH, PH_HOLD} phase_e;
  typedef enum logic [1:0] {RA_DATA = 2'd0, RA_CTRL = 2'd1, RA_STAT = 2'd2} reg_addr_e;

  function automatic logic [3:0] next_slot(input logic [3:0] s);
    return (s == SLOT_ACK) ? SLOT_FIRST : s + 4'd1;
  endfunction

  function automatic logic is_data_slot(input logic [3:0] s);
    return (s >= SLOT_FIRST) && (s <= SLOT_LAST);
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(input logic tx, input logic ack,
                                                 input logic wt, input logic ien);
    return {4'b0, ien, wt, ack, tx};
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input logic irqf, input logic done,
                                                   input logic full);
    return {5'b0, full, done, irqf};
  endfunction
endpackage

// File: rtl/i2cw_half_timer.sv
module i2cw_half_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cw_sampler.sv
module i2cw_sampler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  input  logic         load,
  output logic [W-1:0] byte_q
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      byte_q <= '0;
    end else begin
      if (shift_en) sh <= {sh[W-2:0], bit_in};
      if (load)     byte_q <= sh;
    end
  end
endmodule

// File: rtl/i2cw_flags.sv
module i2cw_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_wait,
  input  logic set_frame,
  input  logic clr_irq,
  input  logic clr_full,
  output logic irq_f,
  output logic done_f,
  output logic full_f
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_f  <= 1'b0;
      done_f <= 1'b0;
      full_f <= 1'b0;
    end else begin
      if (set_wait || set_frame) irq_f <= 1'b1;
      else if (clr_irq)          irq_f <= 1'b0;
      if (set_frame)             done_f <= 1'b1;
      else if (clr_irq)          done_f <= 1'b0;
      if (set_frame)             full_f <= 1'b1;
      else if (clr_full)         full_f <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_rx_wait.sv
module i2c_rx_wait
  import i2cw_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [WR_W-1:0]  reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  phase_e     st_q;
  logic [3:0] slot_q;
  logic       ack_q;
  logic       tx_mode, ack_val, wait_en, irq_en;
  logic       run, tick;
  logic       in_idle, in_hold;
  logic       ev_start, ev_rise, ev_fall, ev_wait8, ev_frame9, ev_resume;
  logic       wr_ctrl, clr_irq, rd_data;
  logic       irq_f, done_f, full_f;
  logic [BYTE_BITS-1:0] rx_byte;

  // register-side decodes
  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign clr_irq = reg_wr && (reg_addr == RA_STAT) && !reg_wdata[0];
  assign rd_data = reg_rd && (reg_addr == RA_DATA);

  // named bus events
  assign in_idle   = (st_q == PH_IDLE);
  assign in_hold   = (st_q == PH_HOLD);
  assign run       = (st_q == PH_LOW) || (st_q == PH_HIGH);
  assign ev_start  = rd_data && !tx_mode && in_idle;
  assign ev_rise   = (st_q == PH_LOW) && tick;
  assign ev_fall   = (st_q == PH_HIGH) && tick;
  assign ev_wait8  = ev_fall && (slot_q == SLOT_LAST) && wait_en;
  assign ev_frame9 = ev_rise && (slot_q == SLOT_ACK);
  assign ev_resume = in_hold && !irq_f;

  i2cw_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  i2cw_sampler #(.W(BYTE_BITS)) u_sampler (
    .clk(clk), .rst_n(rst_n),
    .shift_en(ev_rise && is_data_slot(slot_q)),
    .bit_in(sda_in), .load(ev_frame9), .byte_q(rx_byte)
  );

  i2cw_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_wait(ev_wait8), .set_frame(ev_frame9),
    .clr_irq(clr_irq), .clr_full(rd_data),
    .irq_f(irq_f), .done_f(done_f), .full_f(full_f)
  );

  // control register: transmit mode out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_mode <= 1'b1;
      ack_val <= 1'b0;
      wait_en <= 1'b0;
      irq_en  <= 1'b0;
    end else if (wr_ctrl) begin
      tx_mode <= reg_wdata[0];
      ack_val <= reg_wdata[1];
      wait_en <= reg_wdata[2];
      irq_en  <= reg_wdata[3];
    end
  end

  // acknowledge value is frozen for the whole ninth clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ack_q <= 1'b0;
    else if (slot_q != SLOT_ACK) ack_q <= ack_val;
  end

  // SCL phase sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      slot_q <= '0;
    end else begin
      case (st_q)
        PH_IDLE: if (ev_start) begin
          st_q   <= PH_LOW;
          slot_q <= SLOT_FIRST;
        end
        PH_LOW: if (tick) st_q <= PH_HIGH;
        PH_HIGH: if (ev_fall) begin
          if (ev_wait8) begin
            st_q <= PH_HOLD;
          end else if ((slot_q == SLOT_ACK) && tx_mode) begin
            st_q   <= PH_IDLE;
            slot_q <= '0;
          end else begin
            st_q   <= PH_LOW;
            slot_q <= next_slot(slot_q);
          end
        end
        PH_HOLD: if (ev_resume) begin
          st_q   <= PH_LOW;
          slot_q <= SLOT_ACK;
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  assign scl_oe = (st_q == PH_LOW) || in_hold;
  assign sda_oe = run && (slot_q == SLOT_ACK) && !ack_q;
  assign irq    = irq_f && irq_en;

  always_comb begin
    case (reg_addr)
      RA_DATA: reg_rdata = rx_byte;
      RA_CTRL: reg_rdata = pack_ctrl(tx_mode, ack_val, wait_en, irq_en);
      RA_STAT: reg_rdata = pack_status(irq_f, done_f, full_f);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cw_chk.sv
module i2cw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_wait8,
  input logic       ev_frame9,
  input logic       in_hold,
  input logic       in_idle,
  input logic [3:0] slot,
  input logic       irq_f,
  input logic       done_f,
  input logic       full_f,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe
);
  // R4
  wait_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wait8 |=> (irq_f && !done_f));

  // R4
  hold_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |-> scl_oe);

  // R6
  frame_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame9 |=> (irq_f && done_f && full_f));

  // R5
  ack_slot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (slot == 4'd9));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_f);

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> (!scl_oe && !sda_oe));

  // R7
  hold_only_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_hold) |-> $past(ev_wait8));
endmodule

bind i2c_rx_wait i2cw_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_wait8(ev_wait8), .ev_frame9(ev_frame9),
  .in_hold(in_hold), .in_idle(in_idle), .slot(slot_q),
  .irq_f(irq_f), .done_f(done_f), .full_f(full_f),
  .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/tb_i2c_rx_wait.sv
module tb_i2c_rx_wait;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] b_addr = 2'd2;
  logic       b_wr = 1'b0, b_rd = 1'b0;
  logic [3:0] b_wdata = 4'd0;
  logic [7:0] rdata;
  logic       irq, scl_oe, sda_oe, sda_in;
  logic       slave_bit = 1'b1;

  assign sda_in = sda_oe ? 1'b0 : slave_bit;

  i2c_rx_wait #(.HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(b_addr), .reg_wr(b_wr), .reg_rd(b_rd),
    .reg_wdata(b_wdata), .reg_rdata(rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, sda_cnt = 0, scl_cnt = 0;
  bit finished = 1'b0;
  logic [7:0] pat [0:4] = '{8'hA5, 8'h3C, 8'h81, 8'h5A, 8'hE7};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 SCL low, 2 SCL high, 3 held
  int ms = 0, mcnt = 0, mbit = 0, mframes = 0;
  bit [7:0] msh = 0, mdata = 0;
  bit mirq = 0, mdone = 0, mfull = 0, mtx = 1, mack = 0, mwait = 0, mien = 0, mackq = 0;

  function automatic bit m_scl();  return ms == 1 || ms == 3; endfunction
  function automatic bit m_sda();  return (ms == 1 || ms == 2) && mbit == 9 && !mackq; endfunction
  function automatic bit m_irqo(); return mirq && mien; endfunction
  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return mdata;
      2'd1: return {4'b0, mien, mwait, mack, mtx};
      2'd2: return {5'b0, mfull, mdone, mirq};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int ns, nb;
    bit tick, ni, nd, nf;
    if (!rst_n) begin
      ms = 0; mcnt = 0; mbit = 0; mframes = 0; msh = 0; mdata = 0;
      mirq = 0; mdone = 0; mfull = 0; mtx = 1; mack = 0; mwait = 0; mien = 0; mackq = 0;
    end else begin
      tick = (ms == 1 || ms == 2) && (mcnt == HALF - 1);
      ns = ms; nb = mbit; ni = mirq; nd = mdone; nf = mfull;
      if (b_wr && b_addr == 2'd2 && !b_wdata[0]) begin ni = 0; nd = 0; end
      if (b_rd && b_addr == 2'd0) nf = 0;
      case (ms)
        0: if (b_rd && b_addr == 2'd0 && !mtx) begin ns = 1; nb = 1; end
        1: if (tick) begin
             ns = 2;
             if (mbit <= 8) msh = {msh[6:0], sda_in};
             else begin mdata = msh; ni = 1; nd = 1; nf = 1; mframes++; end
           end
        2: if (tick) begin
             if (mbit == 8 && mwait) begin ns = 3; ni = 1; end
             else if (mbit == 9) begin
               if (mtx) begin ns = 0; nb = 0; end else begin ns = 1; nb = 1; end
             end else begin ns = 1; nb = mbit + 1; end
           end
        default: if (!mirq) begin ns = 1; nb = 9; end
      endcase
      if (!(ms == 1 || ms == 2) || tick) mcnt = 0; else mcnt++;
      if (mbit != 9) mackq = mack;
      if (b_wr && b_addr == 2'd1) begin
        mtx = b_wdata[0]; mack = b_wdata[1]; mwait = b_wdata[2]; mien = b_wdata[3];
      end
      ms = ns; mbit = nb; mirq = ni; mdone = nd; mfull = nf;
    end
  end

  // slave drives its data bit on the far edge
  always @(negedge clk)
    slave_bit = ((ms == 1 || ms == 2) && mbit >= 1 && mbit <= 8) ? pat[mframes % 5][8 - mbit] : 1'b1;

  // per-clock comparison against the reference
  always @(posedge clk) begin
    #3;
    if (rst_n && !finished) begin
      chk("R2 scl_oe", scl_oe, m_scl());
      chk("R5 sda_oe", sda_oe, m_sda());
      chk("R8 irq", irq, m_irqo());
      chk("R6 rdata", rdata, m_read(b_addr));
      if (sda_oe) sda_cnt++;
      if (scl_oe) scl_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk); b_addr = a; b_wdata = d; b_wr = 1'b1;
    @(negedge clk); b_wr = 1'b0; b_addr = 2'd2;
  endtask

  task automatic rd_data(output logic [7:0] v);
    @(negedge clk); b_addr = 2'd0; b_rd = 1'b1; #1 v = rdata;
    @(negedge clk); b_rd = 1'b0; b_addr = 2'd2;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); b_addr = a; #1 v = rdata;
  endtask

  task automatic wait_stat(input logic [7:0] mask, input string tag);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); b_addr = 2'd2; #1;
      if ((rdata & mask) == mask) break;
    end
    chk(tag, rdata & mask, mask);
  endtask

  initial begin
    logic [7:0] v;
    int t1, t2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 irq", irq, 0);
    peek(2'd1, v); chk("R1 ctrl", v, 8'h01);
    peek(2'd2, v); chk("R1 status", v, 8'h00);

    // wait mode, ACK, interrupts enabled
    wr(2'd1, 4'hC);
    rd_data(v);
    wait_stat(8'h01, "R4 wait flag");
    peek(2'd2, v); chk("R4 status at stall", v, 8'h01);
    chk("R8 irq at stall", irq, 1);
    repeat (20) @(negedge clk);
    chk("R4 scl held", scl_oe, 1);
    sda_cnt = 0;
    wr(2'd2, 4'h0);
    wait_stat(8'h02, "R6 frame done");
    peek(2'd2, v); chk("R6 status frame", v, 8'h07);
    rd_data(v); chk("R3 byte0", v, 8'hA5);
    peek(2'd2, v); chk("R9 read clears full", v, 8'h03);
    wr(2'd2, 4'h1);
    peek(2'd2, v); chk("R9 write 1 ignored", v, 8'h03);
    wr(2'd2, 4'h0);
    peek(2'd2, v); chk("R9 clear", v, 8'h00);
    wait_stat(8'h01, "R4 second stall");
    chk("R5 ack cycles", sda_cnt, 2 * HALF);

    // final byte: NACK and switch to transmit while held
    wr(2'd1, 4'hF);
    chk("R10 no early effect", scl_oe, 1);
    sda_cnt = 0;
    wr(2'd2, 4'h0);
    wait_stat(8'h02, "R6 frame done 2");
    scl_cnt = 0;
    rd_data(v); chk("R3 byte1", v, 8'h3C);
    repeat (200) @(negedge clk);
    chk("R10 scl idle", scl_cnt, 0);
    chk("R5 nack", sda_cnt, 0);
    wr(2'd2, 4'h0);

    // continuous mode, interrupts masked
    wr(2'd1, 4'h0);
    rd_data(v);
    wait_stat(8'h02, "R7 done a");
    t1 = cyc;
    chk("R8 masked irq", irq, 0);
    rd_data(v); chk("R3 byte2", v, 8'h81);
    wr(2'd2, 4'h0);
    wait_stat(8'h02, "R7 done b");
    t2 = cyc;
    chk("R7 period", t2 - t1, 18 * HALF);
    rd_data(v); chk("R3 byte3", v, 8'h5A);
    wr(2'd2, 4'h0);
    wr(2'd1, 4'h1);
    wait_stat(8'h02, "R10 last frame");
    rd_data(v); chk("R3 byte4", v, 8'hE7);
    scl_cnt = 0;
    repeat (100) @(negedge clk);
    chk("R10 stopped", scl_cnt, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule